// File: doc/BRIEF.md
# Three-wire serial EEPROM shift engine

This block is a small serial master for EEPROMs that use a clock line, a single shared bidirectional data line and a chip select. A general-purpose pin outside the block drives the chip select. Firmware writes a data byte and then a control byte. Writing the control byte starts a burst of 0 to 8 serial clocks. In a write burst the byte is shifted out MSB first. In a read burst the bits on the data line are captured into the data register. The serial clock is the system clock divided by an even ratio. It idles low, and each bit takes one full serial clock period.

While the burst runs, a busy flag stays high. When busy falls, a one-cycle interrupt pulse is raised. The engine can float the data line right after the last rising clock edge, which hands the line to the EEPROM. It can also keep busy high until the EEPROM pulls the data line high, which the EEPROM does when its internal write cycle has finished. A burst of zero clocks only switches the line between driven and floating, and still produces one busy cycle and an interrupt.

Top module: `eep3w_engine`

## Requirements
- R1: After reset, control readback is 0x00, `irq` is low, `sclk` is low, `sd_oe` is high and `sd_out` is low.
- R2: A `ctl_wr` pulse while idle starts a burst of exactly `wdata[3:0]` rising edges on `sclk`. Values above 8 act as 8. Rising edges within a burst are `SCLK_DIV` system clocks apart.
- R3: In a write burst (`wdata[4]`=0), bit k of the burst (k=0 first) carries data register bit 7-k on `sd_out`. `sd_out` changes only while `sclk` is low.
- R4: In a read burst (`wdata[4]`=1), `sd_oe` is low until the last rising edge. `sd_in` is sampled on each rising edge, MSB first. The data register then holds the N captured bits right-justified, with its upper bits zero.
- R5: With a count of 0, no `sclk` edge is issued. `sd_oe` becomes the inverse of `wdata[5]`, and busy lasts one cycle followed by the interrupt.
- R6: With `wdata[5]`=1, `sd_oe` drops in the same cycle as the last rising edge of `sclk`. With `wdata[5]`=0, the line is driven again after the burst.
- R7: Busy (readback bit 6) is high for the whole burst. `irq` is high for exactly one cycle, in the first cycle with busy low.
- R8: With `wdata[7]`=1 and `wdata[5]`=1, busy stays high after the last clock until a low-to-high transition is seen on `sd_in`. With `wdata[5]`=0, `wdata[7]` has no effect.
- R9: `ctl_wr` and `dat_wr` pulses while busy is high are ignored. They change neither the burst, nor the readback, nor the data register.
- R10: Control readback is {0, busy, hiz, read, count}. The count field returns the clamped count of the last accepted control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| dat_wr | input | 1 | Data register write strobe |
| wdata | input | 8 | Write data for either register |
| ctl_rdata | output | 8 | Control readback {0, busy, hiz, read, count} |
| dat_rdata | output | 8 | Data register contents |
| irq | output | 1 | One-cycle pulse when busy falls |
| sclk | output | 1 | Serial clock, idles low |
| sd_out | output | 1 | Serial data driven toward the EEPROM |
| sd_oe | output | 1 | Output enable for the data line pad |
| sd_in | input | 1 | Serial data sampled from the pad |

## Verification
The wait-for-ready hold is the hardest case to reach from the ports. It needs a write burst with release enabled, a data line kept low well past the last clock, and then a single rising edge. The stimulus holds `sd_in` low for many serial periods and confirms that busy stays high. Only then does it raise the line and expect the interrupt. Writes that arrive while busy is high are placed in the middle of a read burst, timed against `sclk` falling edges. The later readback of the data register then shows whether the writes were dropped.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_WAIT,
    ST_FIN
  } seq_state_t;

  typedef struct packed {
    logic       wfr;
    logic       hiz;
    logic       rd;
    logic [3:0] cnt;
  } eep_cfg_t;

  localparam int CTL_WFR_BIT  = 7;
  localparam int CTL_BUSY_BIT = 6;
  localparam int CTL_HIZ_BIT  = 5;
  localparam int CTL_RD_BIT   = 4;

  // Split a control byte into fields, clamping the clock count to the word size.
  function automatic eep_cfg_t decode_ctl(input logic [7:0] v, input int max_bits);
    eep_cfg_t c;
    c.wfr = v[CTL_WFR_BIT];
    c.hiz = v[CTL_HIZ_BIT];
    c.rd  = v[CTL_RD_BIT];
    c.cnt = (v[3:0] > 4'(max_bits)) ? 4'(max_bits) : v[3:0];
    return c;
  endfunction

endpackage

// File: rtl/eep3w_phase_timer.sv
module eep3w_phase_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] PH_TOP = PW'(HALF - 1);

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0;
    end else if (restart) begin
      ph <= PH_TOP;
    end else if (run) begin
      ph <= (ph == '0) ? PH_TOP : ph - 1'b1;
    end
  end

  assign tick = run && (ph == '0);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    ph <= PH_TOP); // R2

endmodule

// File: rtl/eep3w_shreg.sv
module eep3w_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic              shift_en,
  input  logic              cap_en,
  input  logic              sd_in,
  output logic [DATA_W-1:0] data_q,
  output logic              out_bit
);
  localparam int MSB = DATA_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      out_bit <= 1'b0;
    end else if (load_en) begin
      data_q <= load_val;
    end else if (start_rd) begin
      data_q  <= '0;
      out_bit <= 1'b0;
    end else if (start_wr) begin
      out_bit <= data_q[MSB];
    end else if (shift_en) begin
      data_q  <= {data_q[MSB-1:0], 1'b0};
      out_bit <= data_q[MSB-1];
    end else if (cap_en) begin
      data_q <= {data_q[MSB-1:0], sd_in};
    end
  end

  AST_NO_SHIFT_AND_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !(shift_en && cap_en)); // R4

endmodule

// File: rtl/eep3w_seq.sv
module eep3w_seq
  import eep3w_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  eep_cfg_t cfg_in,
  input  logic     tick,
  input  logic     sd_in,
  output logic     busy,
  output logic     irq,
  output logic     sclk,
  output logic     sd_oe,
  output logic     start_wr,
  output logic     start_rd,
  output logic     shift_en,
  output logic     cap_en,
  output logic     run,
  output eep_cfg_t cfg_q
);
  seq_state_t state;
  logic [3:0] bits_left;
  logic       sd_in_q;
  logic       last_bit;
  logic       ready_rise;
  logic       hold_for_ready;

  assign last_bit       = (bits_left == 4'd1);
  assign ready_rise     = sd_in && !sd_in_q;
  assign hold_for_ready = cfg_q.wfr && cfg_q.hiz;
  assign run            = (state == ST_LO) || (state == ST_HI);
  assign start_wr       = start && !cfg_in.rd && (cfg_in.cnt != 4'd0);
  assign start_rd       = start &&  cfg_in.rd && (cfg_in.cnt != 4'd0);
  assign cap_en         = (state == ST_LO) && tick && cfg_q.rd;
  assign shift_en       = (state == ST_HI) && tick && !last_bit && !cfg_q.rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      irq       <= 1'b0;
      sclk      <= 1'b0;
      sd_oe     <= 1'b1;
      bits_left <= 4'd0;
      cfg_q     <= '0;
      sd_in_q   <= 1'b0;
    end else begin
      irq     <= 1'b0;
      sd_in_q <= sd_in;
      case (state)
        ST_IDLE: begin
          if (start) begin
            cfg_q     <= cfg_in;
            busy      <= 1'b1;
            bits_left <= cfg_in.cnt;
            if (cfg_in.cnt == 4'd0) begin
              sd_oe <= !cfg_in.hiz;
              state <= (cfg_in.wfr && cfg_in.hiz) ? ST_WAIT : ST_FIN;
            end else begin
              sd_oe <= !cfg_in.rd;
              state <= ST_LO;
            end
          end
        end
        ST_LO: begin
          if (tick) begin
            sclk  <= 1'b1;
            state <= ST_HI;
            if (last_bit) sd_oe <= !cfg_q.hiz;
          end
        end
        ST_HI: begin
          if (tick) begin
            sclk      <= 1'b0;
            bits_left <= bits_left - 4'd1;
            if (last_bit) state <= hold_for_ready ? ST_WAIT : ST_FIN;
            else          state <= ST_LO;
          end
        end
        ST_WAIT: begin
          if (ready_rise) state <= ST_FIN;
        end
        ST_FIN: begin
          busy  <= 1'b0;
          irq   <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IRQ_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!busy && $past(busy))); // R7

  AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk); // R2

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LO && cfg_q.rd) |-> !sd_oe); // R4

  AST_HIZ_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HI && last_bit && cfg_q.hiz) |-> !sd_oe); // R6

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !ready_rise) |=> busy); // R8

  AST_NO_WAIT_WITHOUT_HIZ: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> cfg_q.hiz); // R8

endmodule

// File: rtl/eep3w_engine.sv
module eep3w_engine
  import eep3w_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SCLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              dat_wr,
  input  logic [7:0]        wdata,
  output logic [7:0]        ctl_rdata,
  output logic [DATA_W-1:0] dat_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              sd_out,
  output logic              sd_oe,
  input  logic              sd_in
);
  localparam int HALF = (SCLK_DIV < 2) ? 1 : SCLK_DIV / 2;

  eep_cfg_t cfg_new;
  eep_cfg_t cfg_q;
  logic     busy;
  logic     start;
  logic     load_en;
  logic     tick;
  logic     run;
  logic     start_wr;
  logic     start_rd;
  logic     shift_en;
  logic     cap_en;

  assign cfg_new = decode_ctl(wdata, DATA_W);
  assign start   = ctl_wr && !busy;
  assign load_en = dat_wr && !busy && !ctl_wr;

  eep3w_phase_timer #(.HALF(HALF)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .run     (run),
    .tick    (tick)
  );

  eep3w_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cfg_in   (cfg_new),
    .tick     (tick),
    .sd_in    (sd_in),
    .busy     (busy),
    .irq      (irq),
    .sclk     (sclk),
    .sd_oe    (sd_oe),
    .start_wr (start_wr),
    .start_rd (start_rd),
    .shift_en (shift_en),
    .cap_en   (cap_en),
    .run      (run),
    .cfg_q    (cfg_q)
  );

  eep3w_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (wdata[DATA_W-1:0]),
    .start_wr (start_wr),
    .start_rd (start_rd),
    .shift_en (shift_en),
    .cap_en   (cap_en),
    .sd_in    (sd_in),
    .data_q   (dat_rdata),
    .out_bit  (sd_out)
  );

  assign ctl_rdata = {1'b0, busy, cfg_q.hiz, cfg_q.rd, cfg_q.cnt};

  AST_CTL_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && ctl_wr) |=> $stable(ctl_rdata[5:0])); // R9

  AST_DAT_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && dat_wr && !run) |=> $stable(dat_rdata)); // R9

  AST_OUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sd_out)); // R3

  AST_COUNT_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[3:0] <= 4'(DATA_W)); // R10

endmodule

// File: tb/tb_eep3w_engine.sv
`timescale 1ns/1ps
module tb_eep3w_engine;
  localparam int DIV = 4;
  localparam real TCLK = 5.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic       dat_wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic [7:0] dat_rdata;
  logic       irq, sclk, sd_out, sd_oe;
  logic       sd_in = 1'b0;

  int checks = 0;
  int fails  = 0;
  int rise_cnt = 0;
  bit done = 0;
  realtime last_rise = 0.0;

  bit    q_oe[$];
  bit    q_val[$];
  bit    q_chk[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  eep3w_engine #(.DATA_W(8), .SCLK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .dat_wr(dat_wr), .wdata(wdata),
    .ctl_rdata(ctl_rdata), .dat_rdata(dat_rdata), .irq(irq), .sclk(sclk),
    .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every sclk rising edge pops one expected item.
  always @(posedge sclk) begin
    #1;
    if (rise_cnt > 0)
      check(int'(($realtime - last_rise) / TCLK) == DIV && ($realtime - last_rise) < 200.0,
            "R2", "sclk period", int'(($realtime - last_rise) / TCLK), DIV);
    last_rise = $realtime;
    rise_cnt++;
    if (q_oe.size() == 0) begin
      check(0, "R2", "unexpected sclk rise", rise_cnt, 0);
    end else begin
      automatic bit    e_oe  = q_oe.pop_front();
      automatic bit    e_val = q_val.pop_front();
      automatic bit    e_chk = q_chk.pop_front();
      automatic string e_tag = q_tag.pop_front();
      check(sd_oe == e_oe, e_tag, "sd_oe at rise", sd_oe, e_oe);
      if (e_chk) check(sd_out == e_val, "R3", "sd_out at rise", sd_out, e_val);
    end
  end

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic write_dat(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    bit seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(posedge clk); #1;
      if (irq) begin
        seen = 1;
        check(ctl_rdata[6] == 1'b0, "R7", "busy low with irq", ctl_rdata[6], 0);
        @(posedge clk); #1;
        check(irq == 1'b0, "R7", "irq one cycle", irq, 0);
      end
    end
    if (!seen) check(0, tag, "irq timeout", 0, 1);
  endtask

  function automatic int clamp(input int c);
    return (c > 8) ? 8 : c;
  endfunction

  // Write burst: expected bits are taken MSB first from the loaded byte.
  task automatic run_write(input logic [7:0] data, input logic [7:0] ctl);
    int n = clamp(int'(ctl[3:0]));
    bit hz = ctl[5];
    write_dat(data);
    for (int i = 0; i < n; i++) begin
      q_oe.push_back((i == n - 1) ? !hz : 1'b1);
      q_val.push_back(data[7 - i]);
      q_chk.push_back(1'b1);
      q_tag.push_back((i == n - 1) ? "R6" : "R3");
    end
    rise_cnt = 0;
    write_ctl(ctl);
    wait_irq("R7");
    check(rise_cnt == n, "R2", "rise count", rise_cnt, n);
    check(sd_oe == !hz, "R6", "oe after burst", sd_oe, !hz);
    check(q_oe.size() == 0, "R2", "scoreboard drained", q_oe.size(), 0);
  endtask

  // Read burst: the bench plays the EEPROM, presenting bits at sclk falls.
  task automatic run_read(input logic [7:0] pat, input int n, input bit hz, input bit poke);
    logic [7:0] mask = 8'((1 << n) - 1);
    for (int i = 0; i < n; i++) begin
      q_oe.push_back((i == n - 1) ? !hz : 1'b0);
      q_val.push_back(1'b0);
      q_chk.push_back(1'b0);
      q_tag.push_back((i == n - 1) ? "R6" : "R4");
    end
    sd_in = pat[n - 1];
    rise_cnt = 0;
    write_ctl({2'b00, hz, 1'b1, 4'(n)});
    for (int i = n - 2; i >= 0; i--) begin
      @(negedge sclk);
      sd_in = pat[i];
      if (poke && i == n - 2) begin
        @(negedge clk); ctl_wr = 1'b1; dat_wr = 1'b1; wdata = 8'h2F;
        @(negedge clk); ctl_wr = 1'b0; dat_wr = 1'b0;
        check(ctl_rdata == {2'b01, hz, 1'b1, 4'(n)}, "R9", "ctl write ignored while busy",
              ctl_rdata, {2'b01, hz, 1'b1, 4'(n)});
      end
    end
    wait_irq("R7");
    check(dat_rdata == (pat & mask), poke ? "R9" : "R4", "read data", dat_rdata, pat & mask);
    check(rise_cnt == n, "R4", "read rise count", rise_cnt, n);
    check(q_oe.size() == 0, "R4", "scoreboard drained", q_oe.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ctl_rdata == 8'h00, "R1", "reset ctl", ctl_rdata, 0);
    check(irq == 1'b0, "R1", "reset irq", irq, 0);
    check(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
    check(sd_oe == 1'b1, "R1", "reset oe", sd_oe, 1);
    check(sd_out == 1'b0, "R1", "reset sd_out", sd_out, 0);

    // full byte writes, driven and released
    run_write(8'hA5, 8'h08);
    check(ctl_rdata == 8'h08, "R10", "readback after write", ctl_rdata, 8'h08);
    run_write(8'hC3, 8'h26);
    // count above 8 is clamped
    run_write(8'h81, 8'h0F);
    check(ctl_rdata == 8'h08, "R10", "clamped count readback", ctl_rdata, 8'h08);

    // reads
    run_read(8'h16, 5, 1'b1, 1'b0);
    run_read(8'h5C, 8, 1'b0, 1'b0);
    // writes while busy are dropped
    run_read(8'h09, 4, 1'b1, 1'b1);

    // zero-count commands
    rise_cnt = 0;
    write_ctl(8'h20);
    wait_irq("R5");
    check(rise_cnt == 0, "R5", "no clocks hiz", rise_cnt, 0);
    check(sd_oe == 1'b0, "R5", "floated", sd_oe, 0);
    write_ctl(8'h00);
    wait_irq("R5");
    check(rise_cnt == 0, "R5", "no clocks lowz", rise_cnt, 0);
    check(sd_oe == 1'b1, "R5", "driven", sd_oe, 1);

    // wait for ready with release
    sd_in = 1'b0;
    write_dat(8'h3C);
    for (int i = 0; i < 8; i++) begin
      q_oe.push_back((i == 7) ? 1'b0 : 1'b1);
      q_val.push_back(8'h3C >> (7 - i));
      q_chk.push_back(1'b1);
      q_tag.push_back((i == 7) ? "R6" : "R3");
    end
    rise_cnt = 0;
    write_ctl(8'hA8);
    repeat (DIV * 8 + 40) @(posedge clk);
    #1;
    check(ctl_rdata[6] == 1'b1, "R8", "busy held waiting", ctl_rdata[6], 1);
    check(irq == 1'b0, "R8", "no irq while waiting", irq, 0);
    check(rise_cnt == 8, "R8", "rises before wait", rise_cnt, 8);
    @(negedge clk); sd_in = 1'b1;
    wait_irq("R8");
    @(negedge clk); sd_in = 1'b0;

    // wait for ready without release has no effect
    run_write(8'h5A, 8'h84);
    check(ctl_rdata[6] == 1'b0, "R8", "wfr ignored without hiz", ctl_rdata[6], 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule